// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master (64 x 16)

This block drives a three-wire serial EEPROM that holds 64 words of 16 bits. The pins are a chip select, a serial clock and a serial data line towards the device, plus the data line coming back from it. A client asks for one transfer at a time: a read of one word, or a write of one word. It supplies a 6-bit word address and, for a write, 16 bits of data. At the end of a read the block returns the word. At the end of a write it returns a flag that shows whether the device failed to signal completion.

All pin activity advances in phases. A phase lasts `PHASE_CYC` system-clock cycles, and every pin step takes exactly one phase. A read is one command frame followed by sixteen clocked-in bits and a chip-select recovery toggle. A write runs on its own from start to end:

1. Unlock the device.
2. Send the programming frame.
3. Toggle chip select and poll the returned data line for the ready level, for a bounded number of phases.
4. Lock the device again.
5. Close with chip select low and one bare clock pulse.

Top module: `serial_nvm_master`

## Requirements
- R1: A read shifts out the opcode 3'b110 and then the 6-bit address, MSB first. It then clocks in 16 bits, MSB first, sampling `mem_miso_i` at the end of each clock-high phase. The word appears on `rdata_o` together with `done_o`.
- R2: Each outgoing bit takes three phases: the data is presented with the clock low, then the clock is high, then the clock is low again. `mem_mosi_o` never changes while `mem_sck_o` is high. Every clock-high interval with chip select asserted lasts exactly `PHASE_CYC` cycles.
- R3: Out of reset, and whenever a command starts from a deselected device, the clock and `mem_mosi_o` are low at the moment chip select is asserted.
- R4: The recovery toggle has four steps, one phase each: deselect with the clock low, raise the clock, select, lower the clock. One toggle closes every read, so after a read chip select stays high and the clock and data lines are low. The clock is low whenever the block is idle.
- R5: A write sends three frames:
  - the unlock frame 5'b10011 followed by four zero bits;
  - after a recovery toggle, 3'b101, the address and the 16 data bits (MSB first);
  - after the ready poll and another toggle, the lock frame 5'b10000 followed by four zero bits.

  It then drops chip select and data together and gives one clock pulse. A write uses exactly three recovery toggles and 43 clock rises with chip select asserted. It ends with chip select low.
- R6: After the programming frame and a recovery toggle, the block samples `mem_miso_i` once per phase. A high sample ends the poll. If `POLL_MAX` samples are all low, `timeout_o` is set for that write. `timeout_o` is cleared when the next request is accepted. A write that times out lasts exactly (144 + `POLL_MAX`) phases.
- R7: A request is accepted only while `busy_o` is low, and `busy_o` is high from the next cycle. A request made while busy, including in the last busy cycle, is ignored: no transfer starts and the device is not written. Once started, a transfer always runs to `done_o`.
- R8: `done_o` is a one-cycle pulse. It comes in the first cycle in which `busy_o` is low, with `rdata_o` and `timeout_o` valid.
- R9: A read occupies exactly 64 phases, that is 64 x `PHASE_CYC` busy cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, taken only when idle |
| wr_i | input | 1 | 1 = write request, 0 = read request |
| addr_i | input | 6 | Word address |
| wdata_i | input | 16 | Data word for a write |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Word returned by the last read |
| timeout_o | output | 1 | Last write saw no ready level within the poll limit |
| mem_cs_o | output | 1 | Device chip select, active high |
| mem_sck_o | output | 1 | Device serial clock |
| mem_mosi_o | output | 1 | Serial data towards the device |
| mem_miso_i | input | 1 | Serial data and ready level from the device |

## Verification
Two events can meet in the same cycle:
- **Final phase tick and a new request.** The final tick returns the block to idle. The bench raises a request so that it is sampled on exactly that edge, and then checks that `busy_o` stays low and the device write count does not move. It also sends a request in the middle of a read and checks that the read still returns its own word.
- **Poll limit and a late ready.** The last poll sample and a late ready level can coincide. The bench holds the ready level away for a full timeout and checks both the flag and the exact length of the write. It then repeats with a device that answers, and checks that the flag is cleared.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    localparam int ADDR_W      = 6;
    localparam int DATA_W      = 16;
    localparam int OPC_SHORT_W = 3;
    localparam int OPC_LONG_W  = 5;
    localparam int PAD_W       = 4;
    localparam int FRAME_W     = OPC_SHORT_W + ADDR_W + DATA_W;
    localparam int BITCNT_W    = $clog2(FRAME_W);
    localparam int IDX_W       = 4;

    localparam logic [OPC_SHORT_W-1:0] OPC_RD   = 3'b110;
    localparam logic [OPC_SHORT_W-1:0] OPC_WR   = 3'b101;
    localparam logic [OPC_LONG_W-1:0]  OPC_UNLK = 5'b10011;
    localparam logic [OPC_LONG_W-1:0]  OPC_LOCK = 5'b10000;

    // One segment of a transfer; each segment is a run of phases
    typedef enum logic [2:0] {
        SG_IDLE  = 3'd0,
        SG_SETUP = 3'd1,
        SG_OUT   = 3'd2,
        SG_IN    = 3'd3,
        SG_STBY  = 3'd4,
        SG_POLL  = 3'd5,
        SG_CLEAN = 3'd6
    } seg_e;

    typedef enum logic [1:0] {
        FR_READ = 2'd0,
        FR_UNLK = 2'd1,
        FR_PROG = 2'd2,
        FR_LOCK = 2'd3
    } frame_e;

    typedef struct packed {
        seg_e   kind;
        frame_e frame;
    } step_t;

    // Segment list of each transfer kind; past the end it returns idle
    function automatic step_t step_at(input logic wr, input logic [IDX_W-1:0] idx);
        step_t s;
        s.kind  = SG_IDLE;
        s.frame = FR_READ;
        if (!wr) begin
            case (idx)
                4'd0: s.kind = SG_SETUP;
                4'd1: begin s.kind = SG_OUT; s.frame = FR_READ; end
                4'd2: s.kind = SG_IN;
                4'd3: s.kind = SG_STBY;
                default: s.kind = SG_IDLE;
            endcase
        end else begin
            case (idx)
                4'd0: s.kind = SG_SETUP;
                4'd1: begin s.kind = SG_OUT; s.frame = FR_UNLK; end
                4'd2: s.kind = SG_STBY;
                4'd3: begin s.kind = SG_OUT; s.frame = FR_PROG; end
                4'd4: s.kind = SG_STBY;
                4'd5: s.kind = SG_POLL;
                4'd6: s.kind = SG_STBY;
                4'd7: begin s.kind = SG_OUT; s.frame = FR_LOCK; end
                4'd8: s.kind = SG_CLEAN;
                default: s.kind = SG_IDLE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/nvm_phase_tick.sv
module nvm_phase_tick #(
    parameter int PHASE_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        tick_o = 1'b0;
        if (!run_i) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d  = '0;
            tick_o = 1'b1;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/nvm_frame_build.sv
module nvm_frame_build
    import nvm_pkg::*;
(
    input  frame_e              sel_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [FRAME_W-1:0]  word_o,
    output logic [BITCNT_W-1:0] last_o
);
    localparam int SHORT_LEN = OPC_SHORT_W + ADDR_W;
    localparam int LONG_LEN  = OPC_LONG_W + PAD_W;

    // Frames are left aligned: bit FRAME_W-1 goes out first
    always_comb begin
        word_o = '0;
        last_o = BITCNT_W'(SHORT_LEN - 1);
        case (sel_i)
            FR_READ: begin
                word_o = {OPC_RD, addr_i, {DATA_W{1'b0}}};
                last_o = BITCNT_W'(SHORT_LEN - 1);
            end
            FR_UNLK: begin
                word_o = {OPC_UNLK, {(FRAME_W-OPC_LONG_W){1'b0}}};
                last_o = BITCNT_W'(LONG_LEN - 1);
            end
            FR_PROG: begin
                word_o = {OPC_WR, addr_i, wdata_i};
                last_o = BITCNT_W'(FRAME_W - 1);
            end
            default: begin
                word_o = {OPC_LOCK, {(FRAME_W-OPC_LONG_W){1'b0}}};
                last_o = BITCNT_W'(LONG_LEN - 1);
            end
        endcase
    end

endmodule

// File: rtl/serial_nvm_master.sv
module serial_nvm_master
    import nvm_pkg::*;
#(
    parameter int PHASE_CYC = 10,
    parameter int POLL_MAX  = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              timeout_o,
    output logic              mem_cs_o,
    output logic              mem_sck_o,
    output logic              mem_mosi_o,
    input  logic              mem_miso_i
);
    localparam int POLL_W = $clog2(POLL_MAX + 1);
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_MAX - 1);

    typedef struct packed {
        seg_e                kind;
        logic [IDX_W-1:0]    idx;
        logic                wr;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [1:0]          sub;
        logic [BITCNT_W-1:0] bits;
        logic [FRAME_W-1:0]  sr;
        logic [DATA_W-1:0]   rdata;
        logic [POLL_W-1:0]   poll;
        logic                tmo;
        logic                cs;
        logic                sck;
        logic                di;
        logic                done;
    } st_t;

    st_t                 st_d, st_q;
    logic                tick;
    step_t               nxt;
    logic [FRAME_W-1:0]  frame_word;
    logic [BITCNT_W-1:0] frame_last;
    logic                adv;

    assign busy_o = (st_q.kind != SG_IDLE);
    assign nxt    = step_at(st_q.wr, st_q.idx + IDX_W'(1));

    nvm_phase_tick #(.PHASE_CYC(PHASE_CYC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (busy_o),
        .tick_o(tick)
    );

    nvm_frame_build u_frame (
        .sel_i  (nxt.frame),
        .addr_i (st_q.addr),
        .wdata_i(st_q.wdata),
        .word_o (frame_word),
        .last_o (frame_last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        adv       = 1'b0;

        case (st_q.kind)
            SG_IDLE: begin
                if (req_i) begin
                    st_d.wr    = wr_i;
                    st_d.addr  = addr_i;
                    st_d.wdata = wdata_i;
                    st_d.tmo   = 1'b0;
                    st_d.idx   = '0;
                    st_d.sub   = '0;
                    st_d.kind  = SG_SETUP;
                    st_d.sck   = 1'b0;
                    st_d.di    = 1'b0;
                    st_d.cs    = 1'b1;
                end
            end
            SG_SETUP: begin
                if (tick) adv = 1'b1;
            end
            SG_OUT: begin
                if (tick) begin
                    case (st_q.sub)
                        2'd0: begin st_d.sck = 1'b1; st_d.sub = 2'd1; end
                        2'd1: begin st_d.sck = 1'b0; st_d.sub = 2'd2; end
                        default: begin
                            if (st_q.bits == '0) begin
                                adv = 1'b1;
                            end else begin
                                st_d.bits = st_q.bits - BITCNT_W'(1);
                                st_d.sr   = st_q.sr << 1;
                                st_d.di   = st_q.sr[FRAME_W-2];
                                st_d.sub  = 2'd0;
                            end
                        end
                    endcase
                end
            end
            SG_IN: begin
                if (tick) begin
                    if (st_q.sub == 2'd0) begin
                        st_d.rdata = {st_q.rdata[DATA_W-2:0], mem_miso_i};
                        st_d.sck   = 1'b0;
                        st_d.sub   = 2'd1;
                    end else if (st_q.bits == '0) begin
                        adv = 1'b1;
                    end else begin
                        st_d.bits = st_q.bits - BITCNT_W'(1);
                        st_d.sck  = 1'b1;
                        st_d.sub  = 2'd0;
                    end
                end
            end
            SG_STBY: begin
                if (tick) begin
                    case (st_q.sub)
                        2'd0: begin st_d.sck = 1'b1; st_d.sub = 2'd1; end
                        2'd1: begin st_d.cs  = 1'b1; st_d.sub = 2'd2; end
                        2'd2: begin st_d.sck = 1'b0; st_d.sub = 2'd3; end
                        default: adv = 1'b1;
                    endcase
                end
            end
            SG_POLL: begin
                if (tick) begin
                    if (mem_miso_i) begin
                        adv = 1'b1;
                    end else if (st_q.poll == POLL_LAST) begin
                        st_d.tmo = 1'b1;
                        adv      = 1'b1;
                    end else begin
                        st_d.poll = st_q.poll + POLL_W'(1);
                    end
                end
            end
            SG_CLEAN: begin
                if (tick) begin
                    if (st_q.sub == 2'd0) begin
                        st_d.sck = 1'b0;
                        st_d.sub = 2'd1;
                    end else begin
                        adv = 1'b1;
                    end
                end
            end
            default: st_d.kind = SG_IDLE;
        endcase

        // Enter the next segment: the pins of its first phase are set here
        if (adv) begin
            st_d.idx  = st_q.idx + IDX_W'(1);
            st_d.kind = nxt.kind;
            st_d.sub  = '0;
            st_d.di   = 1'b0;
            case (nxt.kind)
                SG_OUT: begin
                    st_d.sr   = frame_word;
                    st_d.bits = frame_last;
                    st_d.di   = frame_word[FRAME_W-1];
                    st_d.sck  = 1'b0;
                end
                SG_IN: begin
                    st_d.bits = BITCNT_W'(DATA_W - 1);
                    st_d.sck  = 1'b1;
                end
                SG_STBY: begin
                    st_d.cs  = 1'b0;
                    st_d.sck = 1'b0;
                end
                SG_POLL:  st_d.poll = '0;
                SG_CLEAN: begin
                    st_d.cs  = 1'b0;
                    st_d.sck = 1'b1;
                end
                SG_IDLE:  st_d.done = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o     = st_q.done;
    assign rdata_o    = st_q.rdata;
    assign timeout_o  = st_q.tmo;
    assign mem_cs_o   = st_q.cs;
    assign mem_sck_o  = st_q.sck;
    assign mem_mosi_o = st_q.di;

endmodule

// File: rtl/serial_nvm_master_chk.sv
module serial_nvm_master_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic sck,
    input logic mosi
);
    // R8: completion is a single-cycle pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: completion coincides with the first idle cycle
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: completion only ever follows a busy cycle
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R7: a running transfer is never abandoned
    a_r7_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R2: outgoing data only moves while the clock is low
    a_r2_data_quiet_high: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> !$past(sck));

    // R4: the serial clock rests low when idle
    a_r4_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

endmodule

bind serial_nvm_master serial_nvm_master_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .busy (busy_o),
    .done (done_o),
    .sck  (mem_sck_o),
    .mosi (mem_mosi_o)
);

// File: tb/serial_nvm_master_test.sv
module serial_nvm_master_test;

    localparam int PHASE    = 10;
    localparam int POLL     = 200;
    localparam int BUSY_CYC = 333;
    localparam int RD_PH    = 64;
    localparam int WR_TO_PH = 144 + POLL;
    localparam int WDOG     = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        busy, done, tmo_o, cs, sck, mosi, miso;
    logic [15:0] rdata;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_total = 0;

    always #4 clk = ~clk;

    serial_nvm_master #(.PHASE_CYC(PHASE), .POLL_MAX(POLL)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
        .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
        .timeout_o(tmo_o), .mem_cs_o(cs), .mem_sck_o(sck),
        .mem_mosi_o(mosi), .mem_miso_i(miso)
    );

    // ---------------- device model and pin monitors ----------------
    logic [15:0] mem [64];
    logic [24:0] shreg;
    int          bitn, rd_idx, busy_cnt;
    logic        rd_active, rd_bit, wen, pend, wen_at_prog, stuck;
    logic [15:0] rd_word, pd;
    logic [5:0]  pa;
    logic        sck_p, cs_p;
    int          wr_count, sb_count, sbs, rise_cs, hi_len, bad_hi;
    int          cs_rise_lo, setup_bad;
    logic        hi_cs;

    function automatic logic [15:0] init_word(input int a);
        logic [15:0] v;
        v = 16'(a * 16'h1357);
        return v ^ 16'hA5C3;
    endfunction

    assign miso = rd_active ? rd_bit : (!stuck && busy_cnt == 0);

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] = init_word(i);
            shreg = '0; bitn = 0; rd_idx = 0; busy_cnt = 0;
            rd_active = 0; rd_bit = 0; wen = 0; pend = 0; wen_at_prog = 0;
            rd_word = '0; pd = '0; pa = '0; sck_p = 0; cs_p = 0;
            wr_count = 0; sb_count = 0; sbs = 0; rise_cs = 0; hi_len = 0;
            bad_hi = 0; cs_rise_lo = 0; setup_bad = 0; hi_cs = 0;
        end else begin
            if (busy_cnt > 0) busy_cnt--;
            if (cs && !cs_p) begin
                bitn = 0; shreg = '0;
                if (!sck_p) begin
                    cs_rise_lo++;
                    if (mosi) setup_bad++;
                end
            end
            if (!cs && cs_p) begin
                rd_active = 0;
                if (pend) begin
                    pend = 0;
                    if (wen) begin mem[pa] = pd; wr_count++; end
                    busy_cnt = BUSY_CYC;
                end
            end
            if (cs && sck && !sck_p) begin
                shreg = {shreg[23:0], mosi};
                bitn++;
                rise_cs++;
                if (rd_active) begin rd_idx--; rd_bit = rd_word[rd_idx]; end
                if (bitn == 5 && shreg[4:0] == 5'b10011) wen = 1;
                if (bitn == 5 && shreg[4:0] == 5'b10000) wen = 0;
                if (bitn == 9 && shreg[8:6] == 3'b110) begin
                    rd_active = 1; rd_word = mem[shreg[5:0]]; rd_idx = 16;
                end
                if (bitn == 25 && shreg[24:22] == 3'b101) begin
                    pend = 1; pa = shreg[21:16]; pd = shreg[15:0]; wen_at_prog = wen;
                end
            end
            // clock-high interval length
            if (sck && !sck_p) begin hi_len = 1; hi_cs = cs; end
            else if (sck) hi_len++;
            if (!sck && sck_p && hi_cs && hi_len != PHASE) bad_hi++;
            // four-step recovery toggle detector
            case (sbs)
                0: if (!cs && cs_p && !sck) sbs = 1;
                1: if (sck && !sck_p) sbs = cs ? 0 : 2; else if (cs) sbs = 0;
                2: if (cs && !cs_p && sck) sbs = 3; else if (!sck) sbs = 0;
                default: if (!sck && sck_p && cs) begin sb_count++; sbs = 0; end
                         else if (!cs) sbs = 0;
            endcase
            sck_p = sck;
            cs_p  = cs;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > WDOG) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc_total, WDOG);
            $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
            $finish;
        end
    end

    // One transfer; poke_at >= 0 raises a stray request at that busy count
    task automatic xfer(input logic w, input logic [5:0] a, input logic [15:0] d,
                        input int poke_at, output logic [15:0] rd,
                        output logic to, output int cyc);
        @(negedge clk);
        req = 1; wr = w; addr = a; wdata = d;
        @(negedge clk);
        req = 0;
        chk("R7", "busy after accept", busy, 1);
        cyc = 0;
        forever begin
            if (done) break;
            if (busy) cyc++;
            if (cyc == poke_at) begin
                req = 1; wr = 1; addr = 6'd9; wdata = 16'h0BAD;
            end else begin
                req = 0;
            end
            @(negedge clk);
        end
        req = 0;
        rd = rdata;
        to = tmo_o;
        chk("R8", "busy low with done", busy, 0);
        @(negedge clk);
        chk("R8", "done single cycle", done, 0);
    endtask

    logic [15:0] shadow [64];
    logic [15:0] rd;
    logic        to;
    int          cyc, sb0, r0, w0, c0;
    logic [5:0]  wa [4];
    logic [15:0] wd [4];

    initial begin
        wa[0] = 6'd0;  wd[0] = 16'hFFFF;
        wa[1] = 6'd63; wd[1] = 16'h0000;
        wa[2] = 6'd21; wd[2] = 16'hA5A5;
        wa[3] = 6'd42; wd[3] = 16'h5A5A;
        stuck = 0;
        for (int i = 0; i < 64; i++) shadow[i] = init_word(i);
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R3", "reset cs", cs, 0);
        chk("R3", "reset sck", sck, 0);
        chk("R3", "reset mosi", mosi, 0);
        chk("R7", "reset busy", busy, 0);
        chk("R8", "reset done", done, 0);

        // R1 R9 R4: read sweep over every address
        for (int a = 0; a < 64; a++) begin
            sb0 = sb_count; r0 = rise_cs;
            xfer(0, 6'(a), 16'h0, -1, rd, to, cyc);
            chk("R1", $sformatf("read data @%0d", a), rd, shadow[a]);
            chk("R9", "read duration", cyc, RD_PH * PHASE);
            chk("R4", "one toggle per read", sb_count - sb0, 1);
            chk("R2", "clock rises per read", rise_cs - r0, 25);
            chk("R4", "cs held after read", cs, 1);
            chk("R4", "sck low after read", sck, 0);
        end

        // R5 R6: writes with a device that answers
        for (int k = 0; k < 4; k++) begin
            sb0 = sb_count; r0 = rise_cs; w0 = wr_count;
            xfer(1, wa[k], wd[k], -1, rd, to, cyc);
            shadow[wa[k]] = wd[k];
            chk("R6", "no timeout", to, 0);
            chk("R5", "three toggles per write", sb_count - sb0, 3);
            chk("R5", "clock rises per write", rise_cs - r0, 43);
            chk("R5", "unlocked at program", wen_at_prog, 1);
            chk("R5", "locked at end", wen, 0);
            chk("R5", "one device write", wr_count - w0, 1);
            chk("R5", "cs low after write", cs, 0);
            chk("R5", "sck low after write", sck, 0);
            // R3: the next command starts from a deselected device
            c0 = cs_rise_lo;
            xfer(0, wa[k], 16'h0, -1, rd, to, cyc);
            chk("R3", "select with clock low", cs_rise_lo - c0, 1);
            chk("R3", "data low at select", setup_bad, 0);
            chk("R5", $sformatf("readback @%0d", wa[k]), rd, wd[k]);
        end

        // R6: device never ready
        stuck = 1;
        xfer(1, 6'd7, 16'h1234, -1, rd, to, cyc);
        shadow[7] = 16'h1234;
        chk("R6", "timeout flag", to, 1);
        chk("R6", "timeout write duration", cyc, WR_TO_PH * PHASE);
        stuck = 0;
        repeat (BUSY_CYC + 5) @(negedge clk);
        xfer(1, 6'd7, 16'h4321, -1, rd, to, cyc);
        shadow[7] = 16'h4321;
        chk("R6", "timeout cleared", to, 0);
        xfer(0, 6'd7, 16'h0, -1, rd, to, cyc);
        chk("R6", "data after recovery", rd, 16'h4321);

        // R7: stray requests mid-read and in the final busy cycle
        w0 = wr_count;
        xfer(0, 6'd5, 16'h0, 100, rd, to, cyc);
        chk("R7", "mid-busy request ignored, data", rd, shadow[5]);
        xfer(0, 6'd6, 16'h0, RD_PH * PHASE, rd, to, cyc);
        chk("R7", "last-cycle request ignored, data", rd, shadow[6]);
        repeat (3 * PHASE) begin
            @(negedge clk);
            if (busy) break;
        end
        chk("R7", "no transfer from stray request", busy, 0);
        chk("R7", "device not written", wr_count - w0, 0);
        chk("R2", "clock-high intervals", bad_hi, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule